// File: doc/BRIEF.md
# Single-Bit Sector ECC Checker and Corrector

This block settles whether one sector of flash data survived the read. It takes two 24-bit single-error-correcting parity codes: the one kept in the flash spare area, given as three bytes, and the one produced by the parity engine while the sector streamed in, given as the engine's raw 32-bit word. It packs the raw word into the stored layout and XORs the two codes into a syndrome. From the syndrome it reports one of four outcomes: the sector is clean, one data bit was corrected, one bit of the stored code itself was flipped, or the damage is beyond repair.

When a data bit is at fault, the block also repairs it. It keeps the sector in a byte-wide RAM that the host fills and drains through a simple port. The block reads the faulty byte, XORs in a one-hot mask and writes the byte back. It then raises a one-cycle completion pulse. Every other outcome leaves the RAM untouched and finishes two cycles earlier.

Top module: `hamfix_top`

## Requirements
- R1: After reset, `done` is 0, `status` is 2'b00, `fixAddr` is 0 and `fixMask` is 0.
- R2: A zero syndrome gives `status` 2'b00 (clean) with `fixAddr` and `fixMask` at 0, and the sector RAM is left unchanged.
- R3: The stored code is {storedB2, storedB1, storedB0}, so byte 0 is the least significant. The computed code is the bitwise inverse of {calcRaw[27:16], calcRaw[11:0]}. Bits 31:28 and 15:12 of `calcRaw` have no effect.
- R4: An erased spare area (all three stored bytes 0xFF) checked against an all-zero raw word is reported clean.
- R5: When syndrome bits [23:12] XOR bits [11:0] equal 12'hFFF and syndrome bits [23:15] are below SECTOR_BYTES, `status` is 2'b01. `fixAddr` is then syndrome bits [23:15] and `fixMask` is 1 shifted left by syndrome bits [14:12].
- R6: After a 2'b01 outcome, the RAM byte at `fixAddr` holds its old value XOR `fixMask`, and no other byte changes.
- R7: Count the edge that samples `start` as edge 0. `done` rises after edge 3 on a correction and after edge 1 on every other outcome. It stays high for exactly one cycle, and the RAM write happens on the edge just before `done` rises.
- R8: A syndrome with exactly one bit set gives `status` 2'b10 with `fixMask` at 0, and the RAM is left unchanged.
- R9: Any other nonzero syndrome gives `status` 2'b11 with `fixMask` at 0, and the RAM is left unchanged. The RAM is written by the block only for a 2'b01 outcome.
- R10: A syndrome that passes the complement test of R5 but whose bits [23:15] are at or above SECTOR_BYTES gives `status` 2'b11.
- R11: A `start` pulse that arrives while an operation is in progress is ignored. It causes no second `done` and does not change the outcome.
- R12: A host write that arrives while an operation is in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check with the codes on the inputs this cycle |
| storedB0 | input | 8 | Stored code, least significant byte |
| storedB1 | input | 8 | Stored code, middle byte |
| storedB2 | input | 8 | Stored code, most significant byte |
| calcRaw | input | 32 | Raw word from the parity engine (two 12-bit halves) |
| hostWe | input | 1 | Host write strobe into the sector RAM |
| hostAddr | input | AW | Host byte address, AW = clog2(SECTOR_BYTES) |
| hostWData | input | 8 | Host write data |
| hostRData | output | 8 | RAM byte at hostAddr, one cycle after the address |
| status | output | 2 | 00 clean, 01 corrected, 10 code-only error, 11 uncorrectable |
| fixAddr | output | 9 | Byte offset of the corrected bit |
| fixMask | output | 8 | One-hot mask of the corrected bit |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds every syndrome from a stored code and a raw word with junk in the ignored bits. A design that dropped the inversion, swapped byte order or used the junk bits would report clean sectors as broken. Corrections are aimed at the first and last byte and at bit 0 and bit 7, and each one is read back through the host port. An off-by-one in the offset slice or the mask shift would flip the wrong bit. Single-bit code errors are placed at bit positions whose upper half would decode to a valid byte address, so a design that mistook them for data errors would corrupt RAM. A second instance with a 256-byte sector catches a missing range check, and start and host-write pulses sent mid-operation catch an FSM that restarts or lets the host clobber the byte being fixed.

// File: rtl/hamfix_pkg.sv
package hamfix_pkg;

  localparam int CODE_W = 24;
  localparam int HALF_W = 12;
  localparam int OFF_W  = 9;
  localparam int BIT_W  = 3;
  localparam int RAW_W  = 32;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'b00,
    ST_FIXED    = 2'b01,
    ST_ECC_ONLY = 2'b10,
    ST_BAD      = 2'b11
  } eccStatus_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;
    logic capture;
    logic ramRead;
    logic ramWrite;
    logic hostOpen;
  } ctlStb_t;

  typedef struct packed {
    eccStatus_e             status;
    logic [OFF_W-1:0]       offset;
    logic [BIT_W-1:0]       bitIdx;
  } verdict_t;

  // raw engine word to storage layout; inversion makes erased pages clean
  function automatic logic [CODE_W-1:0] packRaw(input logic [RAW_W-1:0] raw);
    return ~{raw[27:16], raw[11:0]};
  endfunction

  function automatic verdict_t judge(input logic [CODE_W-1:0] syn,
                                     input int unsigned limit);
    verdict_t v;
    logic [HALF_W-1:0] hiHalf;
    logic [HALF_W-1:0] loHalf;
    hiHalf   = syn[CODE_W-1:HALF_W];
    loHalf   = syn[HALF_W-1:0];
    v.offset = syn[CODE_W-1:CODE_W-OFF_W];
    v.bitIdx = syn[HALF_W+BIT_W-1:HALF_W];
    if (syn == '0) begin
      v.status = ST_CLEAN;
    end else if ((hiHalf ^ loHalf) == {HALF_W{1'b1}}) begin
      if ({{(32-OFF_W){1'b0}}, v.offset} < limit) v.status = ST_FIXED;
      else                                        v.status = ST_BAD;
    end else if ($countones(syn) == 1) begin
      v.status = ST_ECC_ONLY;
    end else begin
      v.status = ST_BAD;
    end
    return v;
  endfunction

endpackage

// File: rtl/hamfix_ctl.sv
module hamfix_ctl
  import hamfix_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    evalFixed,
  output ctlStb_t stb,
  output logic    done
);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_EVAL = 3'd1,
    S_READ = 3'd2,
    S_WRITE = 3'd3,
    S_FIN  = 3'd4
  } ctlState_e;

  ctlState_e state;
  ctlState_e stateNext;

  always_comb begin
    stateNext = state;
    stb       = '0;
    unique case (state)
      S_IDLE: begin
        stb.hostOpen = 1'b1;
        if (start) begin
          stb.latch = 1'b1;
          stateNext = S_EVAL;
        end
      end
      S_EVAL: begin
        stb.capture = 1'b1;
        stateNext   = evalFixed ? S_READ : S_FIN;
      end
      S_READ: begin
        stb.ramRead = 1'b1;
        stateNext   = S_WRITE;
      end
      S_WRITE: begin
        stb.ramWrite = 1'b1;
        stateNext    = S_FIN;
      end
      S_FIN:   stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign done = (state == S_FIN);

endmodule

// File: rtl/hamfix_dp.sv
module hamfix_dp
  import hamfix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int AW = $clog2(SECTOR_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStb_t            stb,
  input  logic [7:0]         storedB0,
  input  logic [7:0]         storedB1,
  input  logic [7:0]         storedB2,
  input  logic [RAW_W-1:0]   calcRaw,
  input  logic               hostWe,
  input  logic [AW-1:0]      hostAddr,
  input  logic [7:0]         hostWData,
  output logic [7:0]         hostRData,
  output eccStatus_e         status,
  output logic [OFF_W-1:0]   fixAddr,
  output logic [7:0]         fixMask,
  output logic               evalFixed
);

  logic [CODE_W-1:0] storedQ;
  logic [CODE_W-1:0] calcQ;
  logic [CODE_W-1:0] syndrome;
  verdict_t          verdict;

  eccStatus_e        statusQ;
  logic [OFF_W-1:0]  fixAddrQ;
  logic [7:0]        fixMaskQ;
  logic [7:0]        rdByteQ;
  logic [7:0]        hostRDataQ;

  logic [7:0]        sectorMem [SECTOR_BYTES];
  logic              memWe;
  logic [AW-1:0]     memAddr;
  logic [7:0]        memWData;
  logic [AW-1:0]     fixIdx;

  // code capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      storedQ <= '0;
      calcQ   <= '0;
    end else if (stb.latch) begin
      storedQ <= {storedB2, storedB1, storedB0};
      calcQ   <= packRaw(calcRaw);
    end
  end

  assign syndrome  = storedQ ^ calcQ;
  assign verdict   = judge(syndrome, SECTOR_BYTES);
  assign evalFixed = (verdict.status == ST_FIXED);

  // verdict registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ  <= ST_CLEAN;
      fixAddrQ <= '0;
      fixMaskQ <= '0;
    end else if (stb.capture) begin
      statusQ <= verdict.status;
      if (evalFixed) begin
        fixAddrQ <= verdict.offset;
        fixMaskQ <= 8'(1) << verdict.bitIdx;
      end else begin
        fixAddrQ <= '0;
        fixMaskQ <= '0;
      end
    end
  end

  // sector RAM with a single write port shared by host and fixer
  assign fixIdx   = fixAddrQ[AW-1:0];
  assign memWe    = stb.ramWrite | (hostWe & stb.hostOpen);
  assign memAddr  = stb.ramWrite ? fixIdx : hostAddr;
  assign memWData = stb.ramWrite ? (rdByteQ ^ fixMaskQ) : hostWData;

  always_ff @(posedge clk) begin
    if (memWe) sectorMem[memAddr] <= memWData;
    hostRDataQ <= sectorMem[hostAddr];
    if (stb.ramRead) rdByteQ <= sectorMem[fixIdx];
  end

  assign hostRData = hostRDataQ;
  assign status    = statusQ;
  assign fixAddr   = fixAddrQ;
  assign fixMask   = fixMaskQ;

endmodule

// File: rtl/hamfix_top.sv
module hamfix_top
  import hamfix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int AW = $clog2(SECTOR_BYTES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [7:0]    storedB0,
  input  logic [7:0]    storedB1,
  input  logic [7:0]    storedB2,
  input  logic [31:0]   calcRaw,
  input  logic          hostWe,
  input  logic [AW-1:0] hostAddr,
  input  logic [7:0]    hostWData,
  output logic [7:0]    hostRData,
  output logic [1:0]    status,
  output logic [8:0]    fixAddr,
  output logic [7:0]    fixMask,
  output logic          done
);

  ctlStb_t    ctlStb;
  logic       evalFixed;
  eccStatus_e dpStatus;

  hamfix_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .evalFixed (evalFixed),
    .stb       (ctlStb),
    .done      (done)
  );

  hamfix_dp #(.SECTOR_BYTES(SECTOR_BYTES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (ctlStb),
    .storedB0  (storedB0),
    .storedB1  (storedB1),
    .storedB2  (storedB2),
    .calcRaw   (calcRaw),
    .hostWe    (hostWe),
    .hostAddr  (hostAddr),
    .hostWData (hostWData),
    .hostRData (hostRData),
    .status    (dpStatus),
    .fixAddr   (fixAddr),
    .fixMask   (fixMask),
    .evalFixed (evalFixed)
  );

  assign status = dpStatus;

endmodule

// File: rtl/hamfix_chk.sv
module hamfix_chk #(
  parameter int SECTOR_BYTES = 512
) (
  input logic       clk,
  input logic       rstN,
  input logic       done,
  input logic [1:0] status,
  input logic [8:0] fixAddr,
  input logic [7:0] fixMask,
  input logic       ramWrite
);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_write_then_done: assert property (@(posedge clk) disable iff (!rstN)
    ramWrite |=> done);

  a_r2_clean_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (done && status == 2'b00) |-> (fixMask == 8'd0 && fixAddr == 9'd0));

  a_r5_fix_onehot: assert property (@(posedge clk) disable iff (!rstN)
    (done && status == 2'b01) |-> ($countones(fixMask) == 1));

  a_r8_ecc_only_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (done && status == 2'b10) |-> (fixMask == 8'd0));

  a_r9_write_only_on_fix: assert property (@(posedge clk) disable iff (!rstN)
    ramWrite |-> (status == 2'b01));

  a_r10_addr_in_sector: assert property (@(posedge clk) disable iff (!rstN)
    (done && status == 2'b01) |-> ({23'd0, fixAddr} < SECTOR_BYTES));

endmodule

bind hamfix_top hamfix_chk #(.SECTOR_BYTES(SECTOR_BYTES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .done     (done),
  .status   (status),
  .fixAddr  (fixAddr),
  .fixMask  (fixMask),
  .ramWrite (ctlStb.ramWrite)
);

// File: tb/sim_hamfix_top.sv
module sim_hamfix_top;

  localparam int CLK_PERIOD = 10;
  localparam int SECT = 512;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  storedB0 = '0, storedB1 = '0, storedB2 = '0;
  logic [31:0] calcRaw = '0;
  logic        hostWe = 1'b0;
  logic [8:0]  hostAddr = '0;
  logic [7:0]  hostWData = '0;
  logic [7:0]  hostRData;
  logic [1:0]  status;
  logic [8:0]  fixAddr;
  logic [7:0]  fixMask;
  logic        done;

  logic [7:0]  rData1;
  logic [1:0]  status1;
  logic [8:0]  fixAddr1;
  logic [7:0]  fixMask1;
  logic        done1;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [SECT];

  always #(CLK_PERIOD/2) clk = ~clk;

  hamfix_top u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .storedB0(storedB0), .storedB1(storedB1), .storedB2(storedB2),
    .calcRaw(calcRaw), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWData(hostWData), .hostRData(hostRData), .status(status),
    .fixAddr(fixAddr), .fixMask(fixMask), .done(done)
  );

  hamfix_top #(.SECTOR_BYTES(256)) u1 (
    .clk(clk), .rstN(rstN), .start(start),
    .storedB0(storedB0), .storedB1(storedB1), .storedB2(storedB2),
    .calcRaw(calcRaw), .hostWe(1'b0), .hostAddr(8'd0),
    .hostWData(8'd0), .hostRData(rData1), .status(status1),
    .fixAddr(fixAddr1), .fixMask(fixMask1), .done(done1)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkRaw(input logic [23:0] stored,
                                        input logic [23:0] syn);
    logic [23:0] p;
    p = ~(stored ^ syn);
    return {4'hA, p[23:12], 4'h5, p[11:0]};  // junk in ignored bits (R3)
  endfunction

  function automatic logic [23:0] fixSyn(input logic [8:0] off, input logic [2:0] b);
    return {off, b, ~{off, b}};
  endfunction

  task automatic readByte(input logic [8:0] a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a;
    @(negedge clk);
    d = hostRData;
  endtask

  // returns done latency in negedges after the start edge (2 = edge 1, 4 = edge 3)
  task automatic runOp(input logic [23:0] stored, input logic [31:0] raw,
                       input bit sneakWr, input bit sneakStart, output int lat);
    @(negedge clk);
    storedB0 = stored[7:0];
    storedB1 = stored[15:8];
    storedB2 = stored[23:16];
    calcRaw  = raw;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat   = 1;
    while (!done && lat < 10) begin
      if (sneakWr && lat == 1) begin
        hostWe = 1'b1; hostAddr = 9'd5; hostWData = ~model[5];
      end else begin
        hostWe = 1'b0;
      end
      if (sneakStart && lat == 2) begin
        start = 1'b1; storedB0 = 8'h00; storedB1 = 8'hFF; storedB2 = 8'h0F;
        calcRaw = 32'h0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    hostWe = 1'b0;
    start  = 1'b0;
    @(negedge clk);
    check(!done, "R7", "done longer than one cycle", int'(done), 0);
  endtask

  task automatic tReset();
    check(done == 1'b0, "R1", "done after reset", int'(done), 0);
    check(status == 2'b00, "R1", "status after reset", int'(status), 0);
    check(fixAddr == 9'd0, "R1", "fixAddr after reset", int'(fixAddr), 0);
    check(fixMask == 8'd0, "R1", "fixMask after reset", int'(fixMask), 0);
  endtask

  task automatic fillRam();
    for (int i = 0; i < SECT; i++) begin
      @(negedge clk);
      model[i]  = 8'((i * 37 + 11) & 255);
      hostWe    = 1'b1;
      hostAddr  = 9'(i);
      hostWData = model[i];
    end
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic tClean();
    int lat;
    logic [7:0] d;
    // byte order: a swapped assembly would give a nonzero syndrome (R3)
    runOp(24'h563412, mkRaw(24'h563412, 24'h0), 1'b0, 1'b0, lat);
    check(status == 2'b00, "R3", "byte order / packing status", int'(status), 0);
    check(lat == 2, "R7", "clean latency", lat, 2);
    runOp(24'hA5C3F0, mkRaw(24'hA5C3F0, 24'h0), 1'b0, 1'b0, lat);
    check(status == 2'b00, "R2", "clean status", int'(status), 0);
    check(fixMask == 8'd0 && fixAddr == 9'd0, "R2", "clean mask/addr",
          int'({fixAddr, fixMask}), 0);
    readByte(9'd0, d);
    check(d == model[0], "R2", "RAM after clean", int'(d), int'(model[0]));
  endtask

  task automatic tErased();
    int lat;
    runOp(24'hFFFFFF, 32'h0, 1'b0, 1'b0, lat);
    check(status == 2'b00, "R4", "erased page status", int'(status), 0);
  endtask

  task automatic tFix(input logic [8:0] off, input logic [2:0] b, input bit sneak);
    int lat;
    logic [7:0] d;
    logic [23:0] st;
    st = 24'h3C5A96 ^ {15'd0, off};
    runOp(st, mkRaw(st, fixSyn(off, b)), sneak, 1'b0, lat);
    check(status == 2'b01, "R5", "fix status", int'(status), 1);
    check(fixAddr == off, "R5", "fix address", int'(fixAddr), int'(off));
    check(fixMask == (8'd1 << b), "R5", "fix mask", int'(fixMask), int'(8'd1 << b));
    check(lat == 4, "R7", "fix latency", lat, 4);
    model[off] = model[off] ^ (8'd1 << b);
    readByte(off, d);
    check(d == model[off], "R6", "corrected byte", int'(d), int'(model[off]));
    if (sneak) begin
      readByte(9'd5, d);
      check(d == model[5], "R12", "host write while busy", int'(d), int'(model[5]));
    end
  endtask

  task automatic tEccOnly(input int k);
    int lat;
    logic [7:0] d;
    logic [23:0] syn;
    syn = 24'd1 << k;
    runOp(24'h123456, mkRaw(24'h123456, syn), 1'b0, 1'b0, lat);
    check(status == 2'b10, "R8", "code-only status", int'(status), 2);
    check(fixMask == 8'd0, "R8", "code-only mask", int'(fixMask), 0);
    readByte(syn[23:15], d);
    check(d == model[syn[23:15]], "R8", "RAM after code-only", int'(d),
          int'(model[syn[23:15]]));
  endtask

  task automatic tBad(input logic [23:0] syn);
    int lat;
    logic [7:0] d;
    runOp(24'h777777, mkRaw(24'h777777, syn), 1'b0, 1'b0, lat);
    check(status == 2'b11, "R9", "uncorrectable status", int'(status), 3);
    check(fixMask == 8'd0, "R9", "uncorrectable mask", int'(fixMask), 0);
    check(lat == 2, "R7", "uncorrectable latency", lat, 2);
    readByte(syn[23:15], d);
    check(d == model[syn[23:15]], "R9", "RAM after uncorrectable", int'(d),
          int'(model[syn[23:15]]));
  endtask

  task automatic tRange();
    int lat;
    runOp(24'h0, mkRaw(24'h0, fixSyn(9'd300, 3'd6)), 1'b0, 1'b0, lat);
    check(status1 == 2'b11, "R10", "offset beyond 256-byte sector", int'(status1), 3);
    check(status == 2'b01, "R10", "same offset inside 512-byte sector", int'(status), 1);
    model[300] = model[300] ^ 8'h40;
    runOp(24'h0, mkRaw(24'h0, fixSyn(9'd100, 3'd1)), 1'b0, 1'b0, lat);
    check(status1 == 2'b01 && fixAddr1 == 9'd100, "R10", "offset inside 256-byte sector",
          int'({status1, fixAddr1}), int'({2'b01, 9'd100}));
    model[100] = model[100] ^ 8'h02;
  endtask

  task automatic tStartIgnored();
    int lat;
    int extra;
    logic [7:0] d;
    runOp(24'h00AA00, mkRaw(24'h00AA00, fixSyn(9'd42, 3'd4)), 1'b0, 1'b1, lat);
    check(status == 2'b01 && fixAddr == 9'd42, "R11", "outcome kept despite restart",
          int'({status, fixAddr}), int'({2'b01, 9'd42}));
    extra = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R11", "second done pulses", extra, 0);
    model[42] = model[42] ^ 8'h10;
    readByte(9'd42, d);
    check(d == model[42], "R11", "byte fixed once", int'(d), int'(model[42]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    fillRam();
    tClean();
    tErased();
    tFix(9'd0, 3'd0, 1'b0);
    tFix(9'd511, 3'd7, 1'b1);
    tFix(9'd200, 3'd3, 1'b0);
    tEccOnly(0);
    tEccOnly(23);
    tEccOnly(14);
    tBad(24'h000003);
    tBad(fixSyn(9'd5, 3'd2) ^ 24'h000001);
    tRange();
    tStartIgnored();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule